// File: doc/BRIEF.md
# E1 Multiframe Status Interrupt Generator

This block raises the receive-side status interrupts of an E1 (2.048 Mbit/s) framer. A bit-rate timing enable paces it. It also sees the basic frame alignment status, the multiframe sync status, the TS16 signalling sync status, a format select (CRC multiframe or doubleframe) and a multiframe-enable control. From these it produces three sticky event bits:
- a multiframe-begin marker, taken from the internal receive line timing;
- a multiframe-search timeout;
- a signalling-changed flag, fed by a 16-entry CAS snapshot that arrives with an update strobe.

A read-clear strobe clears the sticky bits, as it would on a CPU read of a status register. A single interrupt line reports any bit whose mask bit is set. The frame search, the CRC check and the bus decoding are handled elsewhere.

Bit order of the status and mask vectors: bit 0 multiframe begin, bit 1 search timeout, bit 2 signalling changed. With the default parameters one frame is 256 bit periods, a CRC multiframe is 16 frames (4096 bits, 2 ms), a doubleframe is 512 bits, and the search window is 16384 bits (8 ms).

Top module: `e1_mfstat_irq`

## Requirements
- R1: With `crc_mode`=1, status bit 0 is set on the edge that samples every (BPF×FPM)-th `bit_en` pulse after reset, counted on a free-running bit counter.
- R2: With `crc_mode`=0, status bit 0 is set on every (2×BPF)-th `bit_en` pulse instead.
- R3: Status bit 1 is never set while `mf_enable`=0.
- R4: While `mf_enable`=1, `bfa_ok`=1 and `mfa_ok`=0 hold, status bit 1 is set on the TMO_BITS-th `bit_en` pulse of the search. The window then restarts, so it is set again after another TMO_BITS pulses.
- R5: The search window count returns to zero whenever the search condition of R4 is not met. This covers loss of basic alignment, reaching multiframe sync, and disable. Status bit 1 is never set while `mfa_ok`=1.
- R6: On a `cas_upd` pulse, status bit 2 is set on that edge if any 4-bit entry of `cas_in` differs from the snapshot stored at the previous update. An identical snapshot sets nothing.
- R7: Status bit 2 is set only when `bfa_ok`=1 and `ts16_sync`=1 at the update.
- R8: Every update stores the snapshot, including updates taken out of sync, and the stored snapshot is all zeros after reset.
- R9: Status bits stay set until a cycle with `rd_clr`=1, which clears all three. An event in that same cycle leaves its bit set.
- R10: `irq` is 1 exactly when some status bit is 1 and its `irq_mask` bit is 1.
- R11: After reset all status bits and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | One pulse per received bit period |
| crc_mode | input | 1 | 1 = CRC multiframe format, 0 = doubleframe format |
| mf_enable | input | 1 | Enables the multiframe search timeout |
| bfa_ok | input | 1 | Basic (TS0) frame alignment held |
| mfa_ok | input | 1 | Multiframe alignment held |
| ts16_sync | input | 1 | TS16 signalling multiframe sync held |
| cas_upd | input | 1 | Snapshot update strobe |
| cas_in | input | NUM_CH×CAS_W | Signalling snapshot, entry i at bits [i×CAS_W +: CAS_W] |
| rd_clr | input | 1 | Read-clear of all status bits |
| irq_mask | input | 3 | Per-bit interrupt enables |
| irq_stat | output | 3 | Sticky status bits |
| irq | output | 1 | Masked OR of the status bits |

## Verification
Each event passes through one register. A status bit is therefore visible right after the clock edge that samples the causing `bit_en` or `cas_upd` pulse, and `irq` follows the status combinationally. The bench drives inputs on falling edges and samples `irq_stat` and `irq` on the next falling edge after the stimulus edge. Because of this, a count of N pulses is checked at N−1 (expected clear) and again at N (expected set). The bench uses a reduced configuration: 8-bit frames, a 64-bit window, and single-bit flips swept over every snapshot position.

// File: rtl/e1_irq_pkg.sv
package e1_irq_pkg;
  localparam int IRQ_N   = 3;
  localparam int IDX_MFB = 0;
  localparam int IDX_TMO = 1;
  localparam int IDX_CAS = 2;
  typedef logic [IRQ_N-1:0] irq_vec_t;
endpackage

// File: rtl/e1_mfb_gen.sv
module e1_mfb_gen #(
  parameter int BPF = 256,
  parameter int FPM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic crc_mode,
  output logic mfb_ev
);
  localparam int CRC_LEN = BPF * FPM;
  localparam int DF_LEN  = 2 * BPF;
  localparam int CW      = $clog2(CRC_LEN);

  logic [CW-1:0] cnt_q, cnt_d, last_idx;

  always_comb begin
    last_idx = crc_mode ? CW'(CRC_LEN - 1) : CW'(DF_LEN - 1);
    cnt_d    = cnt_q;
    mfb_ev   = 1'b0;
    if (bit_en) begin
      if (cnt_q >= last_idx) begin
        cnt_d  = '0;
        mfb_ev = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (bit_en) cnt_q <= cnt_d;
  end

  AST_MFB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/e1_mf_tmo.sv
module e1_mf_tmo #(
  parameter int TMO_BITS = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic mf_enable,
  input  logic bfa_ok,
  input  logic mfa_ok,
  output logic tmo_ev
);
  localparam int CW = $clog2(TMO_BITS);
  localparam logic [CW-1:0] LAST = CW'(TMO_BITS - 1);

  logic          searching;
  logic [CW-1:0] win_q, win_d;

  always_comb begin
    searching = mf_enable && bfa_ok && !mfa_ok;
    win_d     = win_q;
    tmo_ev    = 1'b0;
    if (!searching) begin
      win_d = '0;
    end else if (bit_en) begin
      if (win_q == LAST) begin
        win_d  = '0;
        tmo_ev = 1'b1;
      end else begin
        win_d = win_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  AST_TMO_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(mf_enable && bfa_ok && !mfa_ok) |=> (win_q == '0)); // R5
endmodule

// File: rtl/e1_cas_cmp.sv
module e1_cas_cmp #(
  parameter int NUM_CH = 16,
  parameter int CAS_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cas_upd,
  input  logic [NUM_CH*CAS_W-1:0] cas_in,
  input  logic                    bfa_ok,
  input  logic                    ts16_sync,
  output logic                    cas_ev
);
  localparam int SW = NUM_CH * CAS_W;

  logic [SW-1:0]     prev_q;
  logic [NUM_CH-1:0] ch_diff;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign ch_diff[i] = (cas_in[i*CAS_W +: CAS_W] != prev_q[i*CAS_W +: CAS_W]);
  end

  always_comb begin
    cas_ev = cas_upd && (|ch_diff) && bfa_ok && ts16_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (cas_upd) prev_q <= cas_in;
  end

  AST_CAS_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    cas_upd |=> (prev_q == $past(cas_in))); // R8
endmodule

// File: rtl/e1_irq_stat.sv
module e1_irq_stat
  import e1_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t ev,
  input  logic     rd_clr,
  input  irq_vec_t mask,
  output irq_vec_t stat,
  output logic     irq
);
  irq_vec_t st_q, st_d;

  for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
    always_comb st_d[i] = (st_q[i] && !rd_clr) || ev[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= st_d[i];
    end
  end

  assign stat = st_q;
  assign irq  = |(st_q & mask);

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((st_q & $past(st_q)) == $past(st_q))); // R9
  AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq); // R10
endmodule

// File: rtl/e1_mfstat_irq.sv
module e1_mfstat_irq
  import e1_irq_pkg::*;
#(
  parameter int BPF      = 256,
  parameter int FPM      = 16,
  parameter int TMO_BITS = 16384,
  parameter int NUM_CH   = 16,
  parameter int CAS_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_en,
  input  logic                    crc_mode,
  input  logic                    mf_enable,
  input  logic                    bfa_ok,
  input  logic                    mfa_ok,
  input  logic                    ts16_sync,
  input  logic                    cas_upd,
  input  logic [NUM_CH*CAS_W-1:0] cas_in,
  input  logic                    rd_clr,
  input  logic [IRQ_N-1:0]        irq_mask,
  output logic [IRQ_N-1:0]        irq_stat,
  output logic                    irq
);
  logic     rst_meta_n, rst_s_n;
  irq_vec_t ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_s_n    <= rst_meta_n;
    end
  end

  e1_mfb_gen #(.BPF(BPF), .FPM(FPM)) u_mfb (
    .clk(clk), .rst_n(rst_s_n), .bit_en(bit_en), .crc_mode(crc_mode),
    .mfb_ev(ev[IDX_MFB])
  );

  e1_mf_tmo #(.TMO_BITS(TMO_BITS)) u_tmo (
    .clk(clk), .rst_n(rst_s_n), .bit_en(bit_en), .mf_enable(mf_enable),
    .bfa_ok(bfa_ok), .mfa_ok(mfa_ok), .tmo_ev(ev[IDX_TMO])
  );

  e1_cas_cmp #(.NUM_CH(NUM_CH), .CAS_W(CAS_W)) u_cas (
    .clk(clk), .rst_n(rst_s_n), .cas_upd(cas_upd), .cas_in(cas_in),
    .bfa_ok(bfa_ok), .ts16_sync(ts16_sync), .cas_ev(ev[IDX_CAS])
  );

  e1_irq_stat u_stat (
    .clk(clk), .rst_n(rst_s_n), .ev(ev), .rd_clr(rd_clr),
    .mask(irq_mask), .stat(irq_stat), .irq(irq)
  );

  AST_MFB_ON_TICK: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq_stat[IDX_MFB]) |-> $past(bit_en)); // R1
  AST_TMO_ONLY_SEARCH: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq_stat[IDX_TMO]) |-> $past(mf_enable && bfa_ok && !mfa_ok)); // R5
  AST_CAS_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(irq_stat[IDX_CAS]) |-> $past(cas_upd && bfa_ok && ts16_sync)); // R7
endmodule

// File: tb/e1_mfstat_irq_tb.sv
module e1_mfstat_irq_tb;
  localparam int BPF = 8, FPM = 16, TMO = 64, NCH = 16, CW = 4;
  localparam int CRC_LEN = BPF * FPM, DF_LEN = 2 * BPF;

  logic clk = 1'b0;
  logic rst_n, bit_en, crc_mode, mf_enable, bfa_ok, mfa_ok, ts16_sync;
  logic cas_upd, rd_clr, irq;
  logic [NCH*CW-1:0] cas_in, cur;
  logic [2:0] irq_mask, irq_stat;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  e1_mfstat_irq #(.BPF(BPF), .FPM(FPM), .TMO_BITS(TMO), .NUM_CH(NCH), .CAS_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .crc_mode(crc_mode),
    .mf_enable(mf_enable), .bfa_ok(bfa_ok), .mfa_ok(mfa_ok), .ts16_sync(ts16_sync),
    .cas_upd(cas_upd), .cas_in(cas_in), .rd_clr(rd_clr), .irq_mask(irq_mask),
    .irq_stat(irq_stat), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) bit_en = 1'b1;
      @(negedge clk) bit_en = 1'b0;
    end
  endtask

  task automatic clr();
    @(negedge clk) rd_clr = 1'b1;
    @(negedge clk) rd_clr = 1'b0;
  endtask

  task automatic upd(input logic [NCH*CW-1:0] v);
    @(negedge clk) begin cas_in = v; cas_upd = 1'b1; end
    @(negedge clk) cas_upd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; crc_mode = 1'b1; mf_enable = 1'b0;
    bfa_ok = 1'b0; mfa_ok = 1'b0; ts16_sync = 1'b0; cas_upd = 1'b0;
    cas_in = '0; rd_clr = 1'b0; irq_mask = 3'b111; cur = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 status", 32'(irq_stat), 0);
    chk("R11 irq", 32'(irq), 0);

    // R1: CRC multiframe period, three periods
    for (int p = 0; p < 3; p++) begin
      pulse(CRC_LEN - 1); chk("R1 early", 32'(irq_stat[0]), 0);
      pulse(1);           chk("R1 due", 32'(irq_stat[0]), 1);
      clr();              chk("R9 clear", 32'(irq_stat), 0);
    end
    chk("R3 no timeout when disabled", 32'(irq_stat[1]), 0);
    // R2: doubleframe period
    crc_mode = 1'b0;
    for (int p = 0; p < 4; p++) begin
      pulse(DF_LEN - 1); chk("R2 early", 32'(irq_stat[0]), 0);
      pulse(1);          chk("R2 due", 32'(irq_stat[0]), 1);
      clr();
    end

    // R4: search timeout and restart
    @(negedge clk) begin mf_enable = 1'b1; bfa_ok = 1'b1; mfa_ok = 1'b0; end
    for (int p = 0; p < 2; p++) begin
      pulse(TMO - 1); chk("R4 early", 32'(irq_stat[1]), 0);
      pulse(1);       chk("R4 due", 32'(irq_stat[1]), 1);
      clr();
    end
    // R5: loss of basic alignment restarts the window
    pulse(40);
    @(negedge clk) bfa_ok = 1'b0;
    @(negedge clk) bfa_ok = 1'b1;
    pulse(TMO - 1); chk("R5 restart early", 32'(irq_stat[1]), 0);
    pulse(1);       chk("R5 restart due", 32'(irq_stat[1]), 1);
    clr();
    // R5: multiframe sync blocks the timeout
    pulse(20);
    @(negedge clk) mfa_ok = 1'b1;
    pulse(3 * TMO); chk("R5 in sync", 32'(irq_stat[1]), 0);
    @(negedge clk) mfa_ok = 1'b0;
    pulse(TMO); chk("R5 resumed search", 32'(irq_stat[1]), 1);
    clr();
    @(negedge clk) mf_enable = 1'b0;
    pulse(3 * TMO); chk("R3 disabled", 32'(irq_stat[1]), 0);
    @(negedge clk) begin mf_enable = 1'b1; bfa_ok = 1'b0; end
    pulse(3 * TMO); chk("R4 no basic alignment", 32'(irq_stat[1]), 0);
    @(negedge clk) begin mf_enable = 1'b0; bfa_ok = 1'b1; ts16_sync = 1'b1; end
    clr();

    // R6: signalling change detection
    upd(cur); chk("R6 equal to reset snapshot", 32'(irq_stat[2]), 0);
    cur = 64'h0123_4567_89AB_CDEF;
    upd(cur); chk("R6 changed", 32'(irq_stat[2]), 1);
    clr();
    upd(cur); chk("R6 repeat", 32'(irq_stat[2]), 0);
    for (int ch = 0; ch < NCH; ch++) begin
      for (int b = 0; b < CW; b++) begin
        cur = cur ^ ((NCH*CW)'(1) << (ch * CW + b));
        upd(cur); chk("R6 single bit flip", 32'(irq_stat[2]), 1);
        clr();
      end
    end
    // R7 / R8: out of sync updates are stored but raise nothing
    @(negedge clk) ts16_sync = 1'b0;
    cur = cur ^ 64'h1; upd(cur); chk("R7 no TS16 sync", 32'(irq_stat[2]), 0);
    @(negedge clk) ts16_sync = 1'b1;
    upd(cur); chk("R8 stored while unsynced", 32'(irq_stat[2]), 0);
    @(negedge clk) bfa_ok = 1'b0;
    cur = cur ^ 64'h2; upd(cur); chk("R7 no basic alignment", 32'(irq_stat[2]), 0);
    @(negedge clk) bfa_ok = 1'b1;
    upd(cur); chk("R8 stored without alignment", 32'(irq_stat[2]), 0);

    // R9: sticky and set-over-clear
    cur = cur ^ 64'h4; upd(cur);
    repeat (10) @(negedge clk);
    chk("R9 held", 32'(irq_stat[2]), 1);
    cur = cur ^ 64'h8;
    @(negedge clk) begin cas_in = cur; cas_upd = 1'b1; rd_clr = 1'b1; end
    @(negedge clk) begin cas_upd = 1'b0; rd_clr = 1'b0; end
    chk("R9 event with clear", 32'(irq_stat[2]), 1);
    clr(); chk("R9 cleared", 32'(irq_stat), 0);

    // R10: mask sweep with all bits set, then with only bit 2 set
    @(negedge clk) begin crc_mode = 1'b1; mf_enable = 1'b1; end
    pulse(CRC_LEN);
    @(negedge clk) mf_enable = 1'b0;
    cur = cur ^ 64'h10; upd(cur);
    chk("R10 all set", 32'(irq_stat), 7);
    for (int m = 0; m < 8; m++) begin
      @(negedge clk) irq_mask = 3'(m);
      @(negedge clk) chk("R10 mask all", 32'(irq), 32'(m != 0));
    end
    clr();
    cur = cur ^ 64'h20; upd(cur);
    for (int m = 0; m < 8; m++) begin
      @(negedge clk) irq_mask = 3'(m);
      @(negedge clk) chk("R10 mask bit2", 32'(irq), 32'((m >> 2) & 1));
    end
    clr();
    @(negedge clk) irq_mask = 3'b111;
    @(negedge clk) chk("R10 nothing pending", 32'(irq), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule